// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave-side serial front end of a byte-wide nonvolatile memory. The four serial pins (select, clock, data in, hold) are sampled in a fast system-clock domain through two-flop synchronisers. Edges of the serial clock are then found by comparing each sample with the one before. The block shifts in an opcode byte and, where the instruction needs one, a 16-bit address. It decodes the instruction and either streams bytes out on a data-out line with an output enable, or hands single-cycle strobes to the memory core.

Toward the core it has a one-cycle-latency array read port, a status byte input and a busy input. It also raises strobes for set write-enable, clear write-enable, status-byte write and data-byte write. The storage array, the protection rules and the timed programming cycle belong to the core. The system clock must run at least eight times faster than the serial clock.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, no instruction is accepted and the output enable stays low until the select input has made a high-to-low transition.
- R2: Opcode 06h raises `wren_stb` and opcode 04h raises `wrdi_stb` for one cycle each. After either, all further clocks in the frame are ignored until the select input goes high.
- R3: An opcode outside {01h, 02h, 03h, 04h, 05h, 06h} produces no strobe and no output for the rest of the frame. The next frame is decoded normally.
- R4: Opcode 03h is followed by a 16-bit address, MSB first, of which only the low `AW` bits are used. The byte at that address is driven MSB first, one bit after each falling serial-clock edge, starting with the falling edge after the last address bit.
- R5: During an array read, the address advances by one after each output byte and wraps from 2^AW-1 to 0. Bytes keep flowing until deselect.
- R6: Opcode 05h drives the status byte repeatedly for as long as the clock runs. Each repeat takes the value `stat_in` has at the start of that byte.
- R7: Opcode 03h received while `busy` is high is rejected. No array read is issued and the output enable stays low until deselect.
- R8: The output enable is low whenever the select input is high.
- R9: With the block selected, hold low and the clock low, a hold begins. During the hold the output enable is low and clock and data edges are ignored. When hold returns high with the clock low, the transfer resumes at the bit where it stopped.
- R10: Deselecting during a hold aborts the transfer. Clocks are ignored while hold stays low, and a new instruction is accepted only after hold is high and select has fallen again.
- R11: Opcode 01h followed by one data byte raises `wrsr_stb` once, with that byte on `wrsr_data`. Later clocks in the frame are ignored.
- R12: Opcode 02h followed by a 16-bit address and N data bytes raises `wdata_stb` N times. Byte k carries the starting address plus k (low `AW` bits) on `wdata_addr`.
- R13: Serial mode 0 (clock idle low) and mode 3 (clock idle high) both work. Data is sampled on rising edges, and a falling edge seen before the first rising edge of a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso`; low means high impedance |
| busy | input | 1 | Core reports an internal write in progress |
| stat_in | input | 8 | Status byte from the core |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_addr | output | AW | Array read address |
| arr_rd_data | input | 8 | Array byte, valid the cycle after `arr_rd_en` |
| wren_stb | output | 1 | Set write-enable strobe |
| wrdi_stb | output | 1 | Clear write-enable strobe |
| wrsr_stb | output | 1 | Status byte received strobe |
| wrsr_data | output | 8 | Status byte received |
| wdata_stb | output | 1 | Data byte received strobe |
| wdata_addr | output | AW | Address of the received data byte |
| wdata | output | 8 | Received data byte |

## Verification
Array reads are swept over several start addresses, one of them just below the top of the array with junk in the unused high address bits. This separates a correct read from a wrong bit order, a missing wrap and a failure to mask the upper bits. Each opcode is sent both alone and followed by extra bytes, which separates correct decoding from a missing lockout after single-byte instructions or invalid codes. The whole sweep runs in both clock polarities. Hold is tried in the middle of an output byte with clock pulses injected, and also with a deselect while held, which separates pausing from aborting.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDARR, ST_RDSTAT, ST_WRSTAT, ST_WRDATA, ST_WAIT
  } st_t;

  localparam logic [7:0] OP_SETWE = 8'h06;
  localparam logic [7:0] OP_CLRWE = 8'h04;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_WRST  = 8'h01;
  localparam logic [7:0] OP_RDARR = 8'h03;
  localparam logic [7:0] OP_WRARR = 8'h02;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_s
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= RST_VAL[g];
        stable <= RST_VAL[g];
      end else begin
        meta   <= pin_in[g];
        stable <= meta;
      end
    end
    assign pin_s[g] = stable;
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spimem_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          hold_s,
  input  logic          busy,
  input  logic [7:0]    stat_in,
  input  logic [7:0]    arr_rd_data,
  output logic          arr_rd_en,
  output logic [AW-1:0] arr_rd_addr,
  output logic          wren_stb,
  output logic          wrdi_stb,
  output logic          wrsr_stb,
  output logic [7:0]    wrsr_data,
  output logic          wdata_stb,
  output logic [AW-1:0] wdata_addr,
  output logic [7:0]    wdata,
  output logic          out_bit,
  output logic          out_drv,
  output logic          hold_act,
  output st_t           state
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  st_t           st;
  logic          sck_d, cs_d, hold_q, drv, wr_mode, rd_pend;
  logic [3:0]    cnt;
  logic [7:0]    sh, nbuf;
  logic [6:0]    osr;
  logic [AW-2:0] ash;
  logic [AW-1:0] addr;

  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire ev_rise  = sck_rise & ~hold_q;
  wire ev_fall  = sck_fall & ~hold_q;
  wire [7:0]    in_byte = {sh[6:0], mosi_s};
  wire [AW-1:0] in_addr = {ash, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sck_d <= 1'b0; cs_d <= 1'b0; hold_q <= 1'b0;
      drv <= 1'b0; wr_mode <= 1'b0; rd_pend <= 1'b0; cnt <= '0;
      sh <= '0; nbuf <= '0; osr <= '0; ash <= '0; addr <= '0; out_bit <= 1'b0;
      arr_rd_en <= 1'b0; wren_stb <= 1'b0; wrdi_stb <= 1'b0;
      wrsr_stb <= 1'b0; wrsr_data <= '0; wdata_stb <= 1'b0; wdata <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      arr_rd_en <= 1'b0; wren_stb <= 1'b0; wrdi_stb <= 1'b0;
      wrsr_stb <= 1'b0; wdata_stb <= 1'b0;
      rd_pend <= arr_rd_en;
      if (rd_pend) nbuf <= arr_rd_data;
      if (wdata_stb) addr <= step(addr);

      if (hold_q) begin
        if (hold_s && !sck_s) hold_q <= 1'b0;
      end else if (st != ST_IDLE && !cs_s && !hold_s && !sck_s) begin
        hold_q <= 1'b1;
      end

      if (cs_s) begin
        st <= ST_IDLE; drv <= 1'b0; cnt <= '0;
      end else if (cs_fall) begin
        st <= ST_OPC; drv <= 1'b0; cnt <= '0;
      end else begin
        case (st)
          ST_OPC: if (ev_rise) begin
            sh  <= in_byte;
            cnt <= cnt + 4'd1;
            if (cnt[2:0] == 3'd7) begin
              cnt <= '0;
              case (in_byte)
                OP_SETWE: begin wren_stb <= 1'b1; st <= ST_WAIT; end
                OP_CLRWE: begin wrdi_stb <= 1'b1; st <= ST_WAIT; end
                OP_RDST:  st <= ST_RDSTAT;
                OP_WRST:  st <= ST_WRSTAT;
                OP_RDARR: begin st <= busy ? ST_WAIT : ST_ADDR; wr_mode <= 1'b0; end
                OP_WRARR: begin st <= ST_ADDR; wr_mode <= 1'b1; end
                default:  st <= ST_WAIT;
              endcase
            end
          end
          ST_ADDR: if (ev_rise) begin
            ash <= in_addr[AW-2:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              cnt  <= '0;
              addr <= in_addr;
              if (wr_mode) st <= ST_WRDATA;
              else begin st <= ST_RDARR; arr_rd_en <= 1'b1; end
            end
          end
          ST_RDARR, ST_RDSTAT: if (ev_fall) begin
            cnt <= {1'b0, cnt[2:0] + 3'd1};
            if (cnt[2:0] == 3'd0) begin
              drv <= 1'b1;
              if (st == ST_RDARR) begin
                {out_bit, osr} <= nbuf;
                addr      <= step(addr);
                arr_rd_en <= 1'b1;
              end else begin
                {out_bit, osr} <= stat_in;
              end
            end else begin
              out_bit <= osr[6];
              osr     <= {osr[5:0], 1'b0};
            end
          end
          ST_WRSTAT: if (ev_rise) begin
            sh  <= in_byte;
            cnt <= cnt + 4'd1;
            if (cnt[2:0] == 3'd7) begin
              wrsr_stb <= 1'b1; wrsr_data <= in_byte; st <= ST_WAIT;
            end
          end
          ST_WRDATA: if (ev_rise) begin
            sh  <= in_byte;
            cnt <= cnt + 4'd1;
            if (cnt[2:0] == 3'd7) begin
              wdata_stb <= 1'b1; wdata <= in_byte; cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign arr_rd_addr = addr;
  assign wdata_addr  = addr;
  assign out_drv     = drv & ~hold_q;
  assign hold_act    = hold_q;
  assign state       = st;
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spimem_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_hold_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          busy,
  input  logic [7:0]    stat_in,
  output logic          arr_rd_en,
  output logic [AW-1:0] arr_rd_addr,
  input  logic [7:0]    arr_rd_data,
  output logic          wren_stb,
  output logic          wrdi_stb,
  output logic          wrsr_stb,
  output logic [7:0]    wrsr_data,
  output logic          wdata_stb,
  output logic [AW-1:0] wdata_addr,
  output logic [7:0]    wdata
);
  localparam int NPIN = 4;
  // bit order {hold, select, clock, data}; select resets low so no false falling edge
  localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

  logic [NPIN-1:0] pins_s;
  logic cs_s, sck_s, mosi_s, hold_s;
  logic out_bit, out_drv, hold_act;
  st_t  fsm_st;

  spi_pin_sync #(.W(NPIN), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_in({spi_hold_n, spi_cs_n, spi_sck, spi_mosi}),
    .pin_s(pins_s)
  );
  assign {hold_s, cs_s, sck_s, mosi_s} = pins_s;

  spi_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s), .hold_s(hold_s),
    .busy(busy), .stat_in(stat_in), .arr_rd_data(arr_rd_data),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .wdata_stb(wdata_stb), .wdata_addr(wdata_addr), .wdata(wdata),
    .out_bit(out_bit), .out_drv(out_drv), .hold_act(hold_act), .state(fsm_st)
  );

  assign spi_miso    = out_bit;
  assign spi_miso_oe = out_drv & ~spi_cs_n;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk
  import spimem_pkg::*;
#(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input st_t           st,
  input logic          hold_q,
  input logic          miso_oe,
  input logic          arr_rd_en,
  input logic [AW-1:0] arr_rd_addr,
  input logic          wren_stb,
  input logic          wrdi_stb,
  input logic          wrsr_stb,
  input logic          wdata_stb
);
  logic          seen;
  logic [AW-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; last <= '0;
    end else if (st != ST_RDARR) begin
      seen <= 1'b0;
    end else if (arr_rd_en) begin
      seen <= 1'b1; last <= arr_rd_addr;
    end
  end

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);

  // R9
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !miso_oe);

  // R9
  hold_nostrobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> !(arr_rd_en | wren_stb | wrdi_stb | wrsr_stb | wdata_stb));

  // R2
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_rd_en, wren_stb, wrdi_stb, wrsr_stb, wdata_stb}));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_en && st == ST_RDARR && seen) |-> (arr_rd_addr == last + 1'b1));

  // R1
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !(wren_stb | wrdi_stb | wrsr_stb | wdata_stb | miso_oe));
endmodule

bind spi_mem_front spi_mem_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .st(fsm_st), .hold_q(hold_act),
  .miso_oe(spi_miso_oe), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
  .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb),
  .wdata_stb(wdata_stb)
);

// File: tb/sim_spi_mem_front.sv
module sim_spi_mem_front;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int AW    = 10;
  localparam int ASZ   = 1 << AW;

  logic clk, rst_n, spi_cs_n, spi_sck, spi_mosi, spi_hold_n, busy, cpol;
  logic spi_miso, spi_miso_oe, arr_rd_en, wren_stb, wrdi_stb, wrsr_stb, wdata_stb;
  logic [7:0] stat_in, arr_rd_data, wrsr_data, wdata, rdq;
  logic [AW-1:0] arr_rd_addr, wdata_addr;
  int nchk, nerr, n_wren, n_wrdi, n_wrsr, n_wd, n_rd, n_oe;
  int wa [0:7];
  int wv [0:7];

  spi_mem_front #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .busy(busy), .stat_in(stat_in),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb),
    .wrsr_data(wrsr_data), .wdata_stb(wdata_stb), .wdata_addr(wdata_addr),
    .wdata(wdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) ^ (a >> 3));
  endfunction

  // core model: one-cycle read latency
  always @(posedge clk) if (arr_rd_en) rdq <= pat(int'(arr_rd_addr));
  assign arr_rd_data = rdq;

  initial begin
    n_wren = 0; n_wrdi = 0; n_wrsr = 0; n_wd = 0; n_rd = 0; n_oe = 0;
  end
  always @(posedge clk) begin
    if (wren_stb) n_wren++;
    if (wrdi_stb) n_wrdi++;
    if (wrsr_stb) n_wrsr++;
    if (arr_rd_en) n_rd++;
    if (spi_miso_oe) n_oe++;
    if (wdata_stb) begin
      if (n_wd < 8) begin wa[n_wd] = int'(wdata_addr); wv[n_wd] = int'(wdata); end
      n_wd++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sel();
    spi_sck = cpol; spi_cs_n = 1'b0; wt(HALF);
  endtask

  task automatic desel();
    if (!cpol) spi_sck = 1'b0;
    wt(HALF); spi_cs_n = 1'b1; wt(2*HALF);
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_sck = 1'b0; spi_mosi = tx[i]; wt(HALF);
      rx[i] = spi_miso_oe ? spi_miso : 1'b1;
      spi_sck = 1'b1; wt(HALF);
    end
  endtask

  task automatic suite();
    logic [7:0] rx;
    int w0, d0, s0, k0, r0, o0, a;
    // R2
    w0 = n_wren; d0 = n_wrdi;
    sel(); xb(8'h06, rx); xb(8'h04, rx); xb(8'h06, rx); desel();
    chk("R2 set-enable strobes once", n_wren, w0 + 1);
    chk("R2 trailing bytes ignored", n_wrdi, d0);
    sel(); xb(8'h04, rx); desel();
    chk("R2 clear-enable strobe", n_wrdi, d0 + 1);
    // R3
    w0 = n_wren;
    sel(); xb(8'hA5, rx); xb(8'h06, rx); xb(8'h05, rx); desel();
    chk("R3 no strobe after invalid opcode", n_wren, w0);
    chk("R3 no output after invalid opcode", int'(rx), 8'hFF);
    sel(); xb(8'h06, rx); desel();
    chk("R3 lockout ends at deselect", n_wren, w0 + 1);
    // R4 R5 R13: sweep start addresses, junk in upper address bits
    for (int k = 0; k < 6; k++) begin
      a = (1022 + k * 173) % ASZ;
      sel(); xb(8'h03, rx); xb({6'h2B, 2'(a >> 8)}, rx); xb(8'(a), rx);
      for (int j = 0; j < 3; j++) begin
        xb(8'h00, rx);
        chk(j == 0 ? "R4 R13 first byte at address" : "R5 increment and wrap",
            int'(rx), int'(pat((a + j) % ASZ)));
      end
      desel();
    end
    // R6
    stat_in = 8'h8C;
    sel(); xb(8'h05, rx); xb(8'h00, rx);
    chk("R6 status byte", int'(rx), 8'h8C);
    stat_in = 8'h03;
    xb(8'h00, rx); chk("R6 status repeat live", int'(rx), 8'h03);
    xb(8'h00, rx); chk("R6 status repeat again", int'(rx), 8'h03);
    desel();
    chk("R8 oe low after deselect", int'(spi_miso_oe), 0);
    // R7
    busy = 1'b1; r0 = n_rd; o0 = n_oe;
    sel(); xb(8'h03, rx); xb(8'h00, rx); xb(8'h10, rx); xb(8'h00, rx); desel();
    busy = 1'b0;
    chk("R7 busy read gives no data", int'(rx), 8'hFF);
    chk("R7 busy read issues no array read", n_rd - r0, 0);
    chk("R7 busy read keeps oe low", n_oe - o0, 0);
    // R11
    s0 = n_wrsr;
    sel(); xb(8'h01, rx); xb(8'h9C, rx); xb(8'h33, rx); desel();
    chk("R11 status write strobe once", n_wrsr, s0 + 1);
    chk("R11 status write data", int'(wrsr_data), 8'h9C);
    // R12
    k0 = n_wd;
    sel(); xb(8'h02, rx); xb(8'hFD, rx); xb(8'h23, rx);
    xb(8'h11, rx); xb(8'h22, rx); xb(8'h33, rx); desel();
    chk("R12 data byte count", n_wd - k0, 3);
    for (int j = 0; j < 3; j++) begin
      chk("R12 data address", wa[k0 + j], 32'h123 + j);
      chk("R12 data value", wv[k0 + j], 32'h11 * (j + 1));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    int a, w0;
    nchk = 0; nerr = 0;
    spi_cs_n = 1'b0; spi_sck = 1'b0; spi_mosi = 1'b0; spi_hold_n = 1'b1;
    busy = 1'b0; stat_in = 8'h00; cpol = 1'b0; rst_n = 1'b0;
    wt(5); rst_n = 1'b1; wt(20);
    // R1: select held low across reset
    chk("R1 oe low after reset", int'(spi_miso_oe), 0);
    xb(8'h06, rx); spi_sck = 1'b0; wt(HALF);
    chk("R1 no instruction without select edge", n_wren, 0);
    spi_cs_n = 1'b1; wt(2*HALF);

    for (int m = 0; m < 2; m++) begin
      cpol = m[0]; spi_sck = cpol; wt(HALF);
      suite();
    end

    // R9: hold in the middle of an output byte, mode 0
    cpol = 1'b0; spi_sck = 1'b0; wt(HALF);
    a = 32'h155;
    sel(); xb(8'h03, rx); xb(8'h01, rx); xb(8'h55, rx);
    rx = 8'h00;
    for (int i = 7; i >= 4; i--) begin
      spi_sck = 1'b0; wt(HALF);
      rx[i] = spi_miso_oe ? spi_miso : 1'b1;
      spi_sck = 1'b1; wt(HALF);
    end
    spi_sck = 1'b0; wt(HALF);
    spi_hold_n = 1'b0; wt(HALF);
    chk("R9 oe low during hold", int'(spi_miso_oe), 0);
    for (int t = 0; t < 3; t++) begin
      spi_sck = 1'b1; wt(HALF); spi_sck = 1'b0; wt(HALF);
    end
    spi_hold_n = 1'b1; wt(HALF);
    rx[3] = spi_miso_oe ? spi_miso : 1'b1;
    spi_sck = 1'b1; wt(HALF);
    for (int i = 2; i >= 0; i--) begin
      spi_sck = 1'b0; wt(HALF);
      rx[i] = spi_miso_oe ? spi_miso : 1'b1;
      spi_sck = 1'b1; wt(HALF);
    end
    chk("R9 byte intact across hold", int'(rx), int'(pat(a)));
    xb(8'h00, rx);
    chk("R9 next byte after hold", int'(rx), int'(pat(a + 1)));
    desel();

    // R10: deselect during hold aborts
    sel(); xb(8'h05, rx);
    spi_sck = 1'b0; wt(HALF);
    spi_hold_n = 1'b0; wt(HALF);
    spi_cs_n = 1'b1; wt(HALF);
    chk("R10 oe low after deselect in hold", int'(spi_miso_oe), 0);
    spi_cs_n = 1'b0; wt(HALF);
    w0 = n_wren;
    xb(8'h06, rx); spi_sck = 1'b0; wt(HALF);
    chk("R10 clocks ignored while hold low", n_wren, w0);
    spi_hold_n = 1'b1; wt(HALF);
    spi_cs_n = 1'b1; wt(2*HALF);
    sel(); xb(8'h06, rx); desel();
    chk("R10 resumes after hold high and reselect", n_wren, w0 + 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule